// File: doc/BRIEF.md
# Coherence Message Event Classifier

This block sits in front of a shared-cache line controller. Each cycle it looks at the heads of three inbound message queues: unblock, response and L1 request. It picks one head by fixed priority and turns that message into a single event code for the controller. The choice of code depends on the message itself and on the directory state of the line it targets. That state covers whether the line is present, its sharer vector, its outstanding-ack count, and whether its set still has a free way. The tag lookup and the victim choice are done outside. The block drives the winning head's address on `lkp_addr`, and the lookup results come back on the same cycle.

The pop strobe for the winning queue is combinational, so the head is consumed in the cycle in which it is classified. The event code and its target address are registered and appear one cycle later. There are two exceptions. A request that misses in a full set becomes a replacement event for the victim line and is left in its queue so that it can be retried once the victim is gone. A head with a type code that is not defined for its queue raises `ev_err`, produces no event and is not popped.

Top module: `coh_evt_classifier`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `ev_vld` and `ev_err` are 0.
- R2: Priority is unblock, then response, then request. At most one of `pop_ub`, `pop_rsp` and `pop_req` is high in any cycle. `lkp_addr` carries the address of the highest-priority valid head.
- R3: Unblock type 0 gives event 16 (plain unblock). Unblock type 1 gives event 17 (exclusive unblock).
- R4: A response from an L1 (`rsp_from_mem`=0) with type 0 (data) gives event 12 when `rsp_dirty`=1 and event 13 when `rsp_dirty`=0.
- R5: A response from an L1 with type 1 (ack) gives event 15 (last ack) when `lkp_pend` minus `rsp_acks`, taken modulo 2^PEND_W, is zero. Otherwise it gives event 14 (partial ack).
- R6: A response from memory (`rsp_from_mem`=1) gives event 9 for type 2 (data), event 10 for type 3 (ack) and event 11 for type 4 (invalidate).
- R7: Requests whose line is present or whose set has a free way decode as follows. Type 0 (read) gives 2, type 1 (instruction read) gives 1, type 2 (write) gives 3. Type 3 (upgrade) from a sharer gives 4. Type 4 (writeback) from a sharer gives 5.
- R8: The sender of a request is a sharer only when `lkp_hit`=1 and bit `req_src` of `lkp_sharers` is 1. An upgrade from a non-sharer gives event 3, the same as a write.
- R9: A writeback request (type 4) from a non-sharer gives event 6 (stale writeback).
- R10: A request with a defined type, `lkp_hit`=0 and `lkp_free_way`=0 gives event 7 when `vict_dirty`=1 and event 8 when `vict_dirty`=0. The event address is `vict_addr`, and `pop_req` stays 0.
- R11: An undefined type code gives `ev_err`=1 one cycle later with `ev_vld`=0, and the head is not popped. The undefined codes are unblock types 2 and 3, L1 response types 2 to 7, memory response types 0, 1, 5, 6 and 7, and request types 5 to 7. The type check takes precedence over the replacement of R10.
- R12: Every popped head yields `ev_vld`=1 in the next cycle, with `ev_addr` equal to the address of the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ub_vld | input | 1 | Unblock queue head valid |
| ub_type | input | 2 | Unblock type code |
| ub_addr | input | ADDR_W | Unblock line address |
| rsp_vld | input | 1 | Response queue head valid |
| rsp_from_mem | input | 1 | Response sender is memory (1) or an L1 (0) |
| rsp_type | input | 3 | Response type code |
| rsp_dirty | input | 1 | Response data dirty flag |
| rsp_acks | input | PEND_W | Ack count carried by the response |
| rsp_addr | input | ADDR_W | Response line address |
| req_vld | input | 1 | Request queue head valid |
| req_type | input | 3 | Request type code |
| req_src | input | SRC_W | Requesting L1 index |
| req_addr | input | ADDR_W | Request line address |
| lkp_addr | output | ADDR_W | Address presented to the external lookup |
| lkp_hit | input | 1 | Line is present |
| lkp_sharers | input | NUM_L1 | Sharer vector of the line |
| lkp_pend | input | PEND_W | Outstanding ack count of the line |
| lkp_free_way | input | 1 | Target set has a free way |
| vict_addr | input | ADDR_W | Victim line address |
| vict_dirty | input | 1 | Victim line dirty flag |
| pop_ub | output | 1 | Dequeue unblock head |
| pop_rsp | output | 1 | Dequeue response head |
| pop_req | output | 1 | Dequeue request head |
| ev_vld | output | 1 | Event valid |
| ev_code | output | 5 | Event code |
| ev_addr | output | ADDR_W | Event target line address |
| ev_err | output | 1 | Undefined type seen on the classified head |

## Verification
Pop strobes and `lkp_addr` depend on the current inputs alone, so they are due in the same cycle as the stimulus. `ev_vld`, `ev_err`, `ev_code` and `ev_addr` are due one clock edge later. The bench drives inputs one time unit after a rising edge and reads the combinational outputs at the following falling edge. It reads the registered outputs one time unit after the next rising edge. At that point it compares them with the expectation its reference model computed from the previous cycle's inputs, so every comparison is made against the edge that produced the value.

// File: rtl/coh_evt_classifier.sv
module coh_evt_classifier #(
  parameter int ADDR_W = 32,
  parameter int NUM_L1 = 8,
  parameter int PEND_W = 4,
  localparam int SRC_W = (NUM_L1 > 1) ? $clog2(NUM_L1) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ub_vld,
  input  logic [1:0]        ub_type,
  input  logic [ADDR_W-1:0] ub_addr,
  input  logic              rsp_vld,
  input  logic              rsp_from_mem,
  input  logic [2:0]        rsp_type,
  input  logic              rsp_dirty,
  input  logic [PEND_W-1:0] rsp_acks,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic              req_vld,
  input  logic [2:0]        req_type,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [ADDR_W-1:0] lkp_addr,
  input  logic              lkp_hit,
  input  logic [NUM_L1-1:0] lkp_sharers,
  input  logic [PEND_W-1:0] lkp_pend,
  input  logic              lkp_free_way,
  input  logic [ADDR_W-1:0] vict_addr,
  input  logic              vict_dirty,
  output logic              pop_ub,
  output logic              pop_rsp,
  output logic              pop_req,
  output logic              ev_vld,
  output logic [4:0]        ev_code,
  output logic [ADDR_W-1:0] ev_addr,
  output logic              ev_err
);

  localparam logic [4:0] EV_RD_INSTR   = 5'd1;
  localparam logic [4:0] EV_RD         = 5'd2;
  localparam logic [4:0] EV_WR         = 5'd3;
  localparam logic [4:0] EV_UPG        = 5'd4;
  localparam logic [4:0] EV_WB         = 5'd5;
  localparam logic [4:0] EV_WB_STALE   = 5'd6;
  localparam logic [4:0] EV_EVICT_D    = 5'd7;
  localparam logic [4:0] EV_EVICT_C    = 5'd8;
  localparam logic [4:0] EV_MEM_DATA   = 5'd9;
  localparam logic [4:0] EV_MEM_ACK    = 5'd10;
  localparam logic [4:0] EV_MEM_INV    = 5'd11;
  localparam logic [4:0] EV_L1_DATA_D  = 5'd12;
  localparam logic [4:0] EV_L1_DATA_C  = 5'd13;
  localparam logic [4:0] EV_ACK_PART   = 5'd14;
  localparam logic [4:0] EV_ACK_LAST   = 5'd15;
  localparam logic [4:0] EV_UNBLK      = 5'd16;
  localparam logic [4:0] EV_UNBLK_X    = 5'd17;

  logic              sel_ub, sel_rsp, sel_req, any_sel;
  logic              bad, evict, is_sharer;
  logic [4:0]        code;
  logic [ADDR_W-1:0] tgt;
  logic [PEND_W-1:0] acks_left;

  assign sel_ub    = ub_vld;
  assign sel_rsp   = !ub_vld && rsp_vld;
  assign sel_req   = !ub_vld && !rsp_vld && req_vld;
  assign any_sel   = sel_ub || sel_rsp || sel_req;
  assign lkp_addr  = sel_ub ? ub_addr : (sel_rsp ? rsp_addr : req_addr);
  assign is_sharer = lkp_hit && lkp_sharers[req_src];
  assign acks_left = lkp_pend - rsp_acks;

  always_comb begin
    code  = '0;
    bad   = 1'b0;
    evict = 1'b0;
    tgt   = lkp_addr;
    if (sel_ub) begin
      case (ub_type)
        2'd0:    code = EV_UNBLK;
        2'd1:    code = EV_UNBLK_X;
        default: bad  = 1'b1;
      endcase
    end else if (sel_rsp) begin
      if (!rsp_from_mem) begin
        case (rsp_type)
          3'd0:    code = rsp_dirty ? EV_L1_DATA_D : EV_L1_DATA_C;
          3'd1:    code = (acks_left == '0) ? EV_ACK_LAST : EV_ACK_PART;
          default: bad  = 1'b1;
        endcase
      end else begin
        case (rsp_type)
          3'd2:    code = EV_MEM_DATA;
          3'd3:    code = EV_MEM_ACK;
          3'd4:    code = EV_MEM_INV;
          default: bad  = 1'b1;
        endcase
      end
    end else if (sel_req) begin
      if (req_type > 3'd4) begin
        bad = 1'b1;
      end else if (!lkp_hit && !lkp_free_way) begin
        evict = 1'b1;
        tgt   = vict_addr;
        code  = vict_dirty ? EV_EVICT_D : EV_EVICT_C;
      end else begin
        case (req_type)
          3'd0:    code = EV_RD;
          3'd1:    code = EV_RD_INSTR;
          3'd2:    code = EV_WR;
          3'd3:    code = is_sharer ? EV_UPG : EV_WR;
          default: code = is_sharer ? EV_WB : EV_WB_STALE;
        endcase
      end
    end
  end

  assign pop_ub  = sel_ub  && !bad;
  assign pop_rsp = sel_rsp && !bad;
  assign pop_req = sel_req && !bad && !evict;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_vld  <= 1'b0;
      ev_err  <= 1'b0;
      ev_code <= '0;
      ev_addr <= '0;
    end else begin
      ev_vld  <= any_sel && !bad;
      ev_err  <= any_sel && bad;
      ev_code <= code;
      ev_addr <= tgt;
    end
  end

  // R2
  pop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pop_ub, pop_rsp, pop_req}));

  // R2
  ub_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ub_vld |-> (!pop_rsp && !pop_req));

  // R11
  err_nopop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |-> $past(!pop_ub && !pop_rsp && !pop_req));

  // R11
  err_noevt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_err && ev_vld));

  // R10
  evict_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vld && (ev_code == EV_EVICT_D || ev_code == EV_EVICT_C)) |-> $past(!pop_req));

  // R12
  pop_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ub || pop_rsp || pop_req) |=> ev_vld);

endmodule

// File: tb/coh_evt_classifier_tb.sv
`timescale 1ns/100ps
module coh_evt_classifier_tb;
  localparam int AW = 32;
  localparam int NL = 8;
  localparam int PW = 4;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ub_vld, rsp_vld, rsp_from_mem, rsp_dirty, req_vld;
  logic lkp_hit, lkp_free_way, vict_dirty;
  logic [1:0] ub_type;
  logic [2:0] rsp_type, req_type;
  logic [PW-1:0] rsp_acks, lkp_pend;
  logic [SW-1:0] req_src;
  logic [NL-1:0] lkp_sharers;
  logic [AW-1:0] ub_addr, rsp_addr, req_addr, vict_addr, lkp_addr, ev_addr;
  logic pop_ub, pop_rsp, pop_req, ev_vld, ev_err;
  logic [4:0] ev_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  coh_evt_classifier #(.ADDR_W(AW), .NUM_L1(NL), .PEND_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ub_vld(ub_vld), .ub_type(ub_type), .ub_addr(ub_addr),
    .rsp_vld(rsp_vld), .rsp_from_mem(rsp_from_mem), .rsp_type(rsp_type),
    .rsp_dirty(rsp_dirty), .rsp_acks(rsp_acks), .rsp_addr(rsp_addr),
    .req_vld(req_vld), .req_type(req_type), .req_src(req_src), .req_addr(req_addr),
    .lkp_addr(lkp_addr), .lkp_hit(lkp_hit), .lkp_sharers(lkp_sharers),
    .lkp_pend(lkp_pend), .lkp_free_way(lkp_free_way),
    .vict_addr(vict_addr), .vict_dirty(vict_dirty),
    .pop_ub(pop_ub), .pop_rsp(pop_rsp), .pop_req(pop_req),
    .ev_vld(ev_vld), .ev_code(ev_code), .ev_addr(ev_addr), .ev_err(ev_err)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    ub_vld = 0; ub_type = 0; ub_addr = 32'h100;
    rsp_vld = 0; rsp_from_mem = 0; rsp_type = 0; rsp_dirty = 0; rsp_acks = 0; rsp_addr = 32'h200;
    req_vld = 0; req_type = 0; req_src = 0; req_addr = 32'h300;
    lkp_hit = 1; lkp_sharers = 0; lkp_pend = 0; lkp_free_way = 1;
    vict_addr = 32'h400; vict_dirty = 0;
  endtask

  // Behavioural reference: what the block must do for the inputs now applied
  task automatic model(output bit pu, output bit pr, output bit pq, output logic [AW-1:0] la,
                       output bit v, output bit e, output int code, output logic [AW-1:0] ta,
                       output string tag);
    bit sharer;
    pu = 0; pr = 0; pq = 0; v = 0; e = 0; code = 0; ta = '0; la = req_addr; tag = "R2";
    if (ub_vld) begin
      la = ub_addr; ta = ub_addr; tag = "R3";
      if (ub_type == 2'd0) code = 16;
      else if (ub_type == 2'd1) code = 17;
      else begin e = 1; tag = "R11"; end
      pu = !e;
    end else if (rsp_vld) begin
      la = rsp_addr; ta = rsp_addr;
      if (rsp_from_mem) begin
        tag = "R6";
        if (rsp_type == 3'd2) code = 9;
        else if (rsp_type == 3'd3) code = 10;
        else if (rsp_type == 3'd4) code = 11;
        else begin e = 1; tag = "R11"; end
      end else if (rsp_type == 3'd0) begin
        tag = "R4"; code = rsp_dirty ? 12 : 13;
      end else if (rsp_type == 3'd1) begin
        tag = "R5"; code = (lkp_pend == rsp_acks) ? 15 : 14;
      end else begin
        e = 1; tag = "R11";
      end
      pr = !e;
    end else if (req_vld) begin
      la = req_addr; ta = req_addr;
      sharer = (lkp_hit == 1'b1) && (lkp_sharers[req_src] == 1'b1);
      if (req_type >= 3'd5) begin
        e = 1; tag = "R11";
      end else if (!lkp_hit && !lkp_free_way) begin
        tag = "R10"; ta = vict_addr; code = vict_dirty ? 7 : 8;
      end else begin
        pq = 1; tag = "R7";
        case (req_type)
          3'd0: code = 2;
          3'd1: code = 1;
          3'd2: code = 3;
          3'd3: begin code = sharer ? 4 : 3; if (!sharer) tag = "R8"; end
          default: begin code = sharer ? 5 : 6; if (!sharer) tag = "R9"; end
        endcase
      end
    end
    v = (ub_vld || rsp_vld || req_vld) && !e;
  endtask

  task automatic cyc();
    bit pu, pr, pq, v, e;
    int code;
    logic [AW-1:0] la, ta;
    string tag;
    #1;
    model(pu, pr, pq, la, v, e, code, ta, tag);
    chk((pu || pr || pq) ? tag : "R2", "pop_ub", pop_ub, pu);
    chk(tag, "pop_rsp", pop_rsp, pr);
    chk(tag, "pop_req", pop_req, pq);
    if (ub_vld || rsp_vld || req_vld) chk("R2", "lkp_addr", lkp_addr, la);
    @(posedge clk); #1;
    chk(v ? "R12" : tag, "ev_vld", ev_vld, v);
    chk(tag, "ev_err", ev_err, e);
    if (v) begin
      chk(tag, "ev_code", ev_code, code);
      chk(v ? "R12" : tag, "ev_addr", ev_addr, ta);
    end
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "ev_vld in reset", ev_vld, 0);
    chk("R1", "ev_err in reset", ev_err, 0);
    ub_vld = 1; ub_type = 2;
    @(posedge clk); #1;
    chk("R1", "ev_err held by reset", ev_err, 0);
    idle();
    rst_n = 1;
    chk("R1", "ev_vld after reset", ev_vld, 0);
    cyc();

    // R3 unblock decode
    idle(); ub_vld = 1; ub_type = 0; ub_addr = 32'h1000; cyc();
    idle(); ub_vld = 1; ub_type = 1; ub_addr = 32'h1040; cyc();
    // R2 priority
    idle(); ub_vld = 1; rsp_vld = 1; req_vld = 1; cyc();
    idle(); rsp_vld = 1; rsp_from_mem = 1; rsp_type = 2; req_vld = 1; cyc();
    // R4 L1 data
    idle(); rsp_vld = 1; rsp_type = 0; rsp_dirty = 1; rsp_addr = 32'h2000; cyc();
    idle(); rsp_vld = 1; rsp_type = 0; rsp_dirty = 0; cyc();
    // R5 acks
    idle(); rsp_vld = 1; rsp_type = 1; lkp_pend = 3; rsp_acks = 3; cyc();
    idle(); rsp_vld = 1; rsp_type = 1; lkp_pend = 3; rsp_acks = 1; cyc();
    idle(); rsp_vld = 1; rsp_type = 1; lkp_pend = 0; rsp_acks = 0; cyc();
    // R6 memory
    for (int t = 2; t <= 4; t++) begin
      idle(); rsp_vld = 1; rsp_from_mem = 1; rsp_type = 3'(t); cyc();
    end
    // R7 requests from a sharer
    for (int t = 0; t <= 4; t++) begin
      idle(); req_vld = 1; req_type = 3'(t); req_src = 5; lkp_sharers = 8'h20;
      req_addr = 32'h3000 + 32'(t); cyc();
    end
    // R8 upgrade from non-sharer, hit and miss-with-free-way
    idle(); req_vld = 1; req_type = 3; req_src = 2; lkp_sharers = 8'hFB; cyc();
    idle(); req_vld = 1; req_type = 3; req_src = 2; lkp_hit = 0; lkp_sharers = 8'hFF; cyc();
    // R9 stale writeback
    idle(); req_vld = 1; req_type = 4; req_src = 7; lkp_sharers = 8'h7F; cyc();
    // R10 replacement
    idle(); req_vld = 1; req_type = 0; lkp_hit = 0; lkp_free_way = 0; vict_dirty = 1; vict_addr = 32'h5500; cyc();
    idle(); req_vld = 1; req_type = 2; lkp_hit = 0; lkp_free_way = 0; vict_dirty = 0; vict_addr = 32'h5600; cyc();
    idle(); req_vld = 1; req_type = 1; lkp_hit = 1; lkp_free_way = 0; cyc();
    // R11 undefined codes
    idle(); ub_vld = 1; ub_type = 3; req_vld = 1; cyc();
    idle(); rsp_vld = 1; rsp_type = 5; cyc();
    idle(); rsp_vld = 1; rsp_from_mem = 1; rsp_type = 1; cyc();
    idle(); req_vld = 1; req_type = 6; lkp_hit = 0; lkp_free_way = 0; cyc();

    // random sweep, reference compared every cycle
    for (int i = 0; i < 3000; i++) begin
      ub_vld = ($urandom % 5) == 0; ub_type = 2'($urandom % 4); ub_addr = $urandom;
      rsp_vld = ($urandom % 3) == 0; rsp_from_mem = 1'($urandom); rsp_type = 3'($urandom % 6);
      rsp_dirty = 1'($urandom); rsp_acks = PW'($urandom % 4); rsp_addr = $urandom;
      req_vld = 1'($urandom); req_type = 3'($urandom % 6); req_src = SW'($urandom);
      req_addr = $urandom; lkp_hit = 1'($urandom); lkp_sharers = NL'($urandom);
      lkp_pend = PW'($urandom % 4); lkp_free_way = 1'($urandom);
      vict_addr = $urandom; vict_dirty = 1'($urandom);
      cyc();
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule